// File: doc/BRIEF.md
# Bit-Manipulation Logic Unit with Flags

This block performs one of six 64-bit bit-manipulation operations per clock, chosen by a 3-bit opcode. Two operand buses feed it. The first is always the data source. The second is either the complement mask for and-not or a control word that carries field positions. Every operation produces a 64-bit result together with carry, zero, sign, overflow, parity and auxiliary-carry flag values. Each flag has its own write-enable, so the surrounding flag register only updates the flags that the operation defines. In particular, parity stays with the caller for every operation except field extract.

The unit has three parts. A small decoder turns the opcode into a struct of strobes. A purely combinational datapath computes the result and the flags. A single register stage captures the result, the flags and the enables, and qualifies them with a valid bit. An input marked valid on one rising edge shows up on the outputs after that edge, with exactly one cycle of latency.

Top module: `bitmanip_flag_unit`

## Requirements
- R1: Opcode 0 (and-not) returns opA AND NOT opB.
- R2: Opcode 1 (isolate lowest set bit) returns (0 - opA) AND opA. Carry is 1 exactly when opA is nonzero.
- R3: Opcode 2 (mask through lowest set bit) returns (opA - 1) XOR opA. Carry is 1 exactly when opA is zero.
- R4: Opcode 3 (clear lowest set bit) returns (opA - 1) AND opA. Carry is 1 exactly when opA is zero.
- R5: For opcodes 0, 1, 2, 3 and 5:
  - zero is 1 when the result is 0;
  - sign equals result bit 63;
  - overflow is 0;
  - the carry, zero, sign and overflow enables are 1;
  - the parity enable is 0.
- R6: Opcode 4 (field extract) reads a start position from opB[7:0] and a length from opB[15:8]. It returns opA shifted right by the start, keeping only the low length bits.
- R7: Field extract returns 0 when the start is 64 or more, or when the length is 0. A length of 64 or more applies no mask.
- R8: Field extract clears carry and overflow. It sets parity to 1 when result[7:0] holds an even number of ones. All five enables for carry, zero, sign, overflow and parity are 1.
- R9: Opcode 5 (zero high bits) reads an index from opB[7:0].
  - For an index below 64, it keeps result bits below the index, clears all others, and sets carry to 0.
  - For an index of 64 or more, it returns opA unchanged and sets carry to 1.
- R10: The auxiliary-carry output and its enable are always 0.
- R11: Results appear one clock after the edge that samples inValid=1, with outValid=1. A cycle that samples inValid=0 gives outValid=0 and all enables 0.
- R12: Opcodes 6 and 7 give a zero result and assert no flag enable.
- R13: While rstN is low, outValid, the result and all enables read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 3 | Operation select (0..5 defined) |
| opA | input | 64 | Source operand |
| opB | input | 64 | Complement mask (and-not) or control word |
| outValid | output | 1 | Registered result is valid |
| result | output | 64 | Registered result |
| cfOut | output | 1 | Carry flag value |
| zfOut | output | 1 | Zero flag value |
| sfOut | output | 1 | Sign flag value |
| ofOut | output | 1 | Overflow flag value |
| pfOut | output | 1 | Parity flag value |
| afOut | output | 1 | Auxiliary-carry flag value (always 0) |
| cfWe | output | 1 | Carry flag write-enable |
| zfWe | output | 1 | Zero flag write-enable |
| sfWe | output | 1 | Sign flag write-enable |
| ofWe | output | 1 | Overflow flag write-enable |
| pfWe | output | 1 | Parity flag write-enable |
| afWe | output | 1 | Auxiliary-carry write-enable (always 0) |

## Verification
Every result, flag and enable is due exactly one rising edge after the edge that samples the operation, because a single register stage sits between the ports. The bench applies one operation at each falling edge. It pushes the reference model's prediction for that operation onto a queue. At the next falling edge, one edge later, it pops the prediction and compares it against the outputs before driving the following operation. Idle cycles are mixed in so that the dropped valid and the cleared enables are checked in the cycle they are due.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_ANDNOT  = 3'd0,
    OP_ISOLATE = 3'd1,
    OP_MASKLOW = 3'd2,
    OP_CLRLOW  = 3'd3,
    OP_FIELD   = 3'd4,
    OP_ZEROHI  = 3'd5
  } bmuOp_e;

  // Strobes from decoder to datapath
  typedef struct packed {
    logic selAndNot;
    logic selIsolate;
    logic selMaskLow;
    logic selClrLow;
    logic selField;
    logic selZeroHi;
    logic carryOnZero;     // carry = source is zero
    logic carryOnNonZero;  // carry = source is nonzero
    logic wrArith;         // carry/zero/sign/overflow enables
    logic wrParity;        // parity enable
  } bmuStrobe_t;

endpackage

// File: rtl/bmu_ctrl.sv
module bmu_ctrl
  import bmu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output bmuStrobe_t       strobe
);

  always_comb begin
    strobe = '0;
    case (opcode)
      OP_ANDNOT: begin
        strobe.selAndNot = 1'b1;
        strobe.wrArith   = 1'b1;
      end
      OP_ISOLATE: begin
        strobe.selIsolate     = 1'b1;
        strobe.carryOnNonZero = 1'b1;
        strobe.wrArith        = 1'b1;
      end
      OP_MASKLOW: begin
        strobe.selMaskLow  = 1'b1;
        strobe.carryOnZero = 1'b1;
        strobe.wrArith     = 1'b1;
      end
      OP_CLRLOW: begin
        strobe.selClrLow   = 1'b1;
        strobe.carryOnZero = 1'b1;
        strobe.wrArith     = 1'b1;
      end
      OP_FIELD: begin
        strobe.selField = 1'b1;
        strobe.wrArith  = 1'b1;
        strobe.wrParity = 1'b1;
      end
      OP_ZEROHI: begin
        strobe.selZeroHi = 1'b1;
        strobe.wrArith   = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

  logic [5:0] selVec;
  assign selVec = {strobe.selAndNot, strobe.selIsolate, strobe.selMaskLow,
                   strobe.selClrLow, strobe.selField, strobe.selZeroHi};

  // R12: at most one operation selected, none for undefined codes
  always_comb begin
    assert_sel_onehot_R12: assert ($onehot0(selVec));
    if (strobe.carryOnZero)
      assert_carry_rule_R3: assert (!strobe.carryOnNonZero);
  end

endmodule

// File: rtl/bmu_datapath.sv
module bmu_datapath
  import bmu_pkg::*;
#(
  parameter int DATA_W       = 64,
  parameter int CTRL_FIELD_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  bmuStrobe_t        strobe,
  output logic [DATA_W-1:0] resultD,
  output logic              cfD,
  output logic              zfD,
  output logic              sfD,
  output logic              ofD,
  output logic              pfD
);

  localparam int PAR_W = (DATA_W < 8) ? DATA_W : 8;

  logic [CTRL_FIELD_W-1:0] startIdx;
  logic [CTRL_FIELD_W-1:0] lenVal;
  logic [CTRL_FIELD_W-1:0] zhIdx;
  assign startIdx = opB[CTRL_FIELD_W-1:0];
  assign lenVal   = opB[2*CTRL_FIELD_W-1:CTRL_FIELD_W];
  assign zhIdx    = opB[CTRL_FIELD_W-1:0];

  // lowest-set-bit family
  logic [DATA_W-1:0] srcMinusOne;
  logic [DATA_W-1:0] srcNeg;
  logic              srcZero;
  assign srcMinusOne = opA - DATA_W'(1);
  assign srcNeg      = '0 - opA;
  assign srcZero     = (opA == '0);

  logic [DATA_W-1:0] andNotRes, isolateRes, maskLowRes, clrLowRes;
  assign andNotRes  = opA & ~opB;
  assign isolateRes = srcNeg & opA;
  assign maskLowRes = srcMinusOne ^ opA;
  assign clrLowRes  = srcMinusOne & opA;

  // field extract and zero-high masks
  logic [DATA_W-1:0] fieldMask;
  logic [DATA_W-1:0] zhMask;
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign fieldMask[i] = (i < int'(lenVal));
    assign zhMask[i]    = (i < int'(zhIdx));
  end

  logic              fieldInRange;
  logic [DATA_W-1:0] fieldShifted;
  logic [DATA_W-1:0] fieldRes;
  assign fieldInRange = (int'(startIdx) < DATA_W);
  assign fieldShifted = fieldInRange ? (opA >> startIdx) : '0;
  assign fieldRes     = fieldShifted & fieldMask;

  logic              zhOver;
  logic [DATA_W-1:0] zeroHiRes;
  assign zhOver    = (int'(zhIdx) >= DATA_W);
  assign zeroHiRes = zhOver ? opA : (opA & zhMask);

  // AND-OR result select
  always_comb begin
    resultD = ({DATA_W{strobe.selAndNot}}  & andNotRes)
            | ({DATA_W{strobe.selIsolate}} & isolateRes)
            | ({DATA_W{strobe.selMaskLow}} & maskLowRes)
            | ({DATA_W{strobe.selClrLow}}  & clrLowRes)
            | ({DATA_W{strobe.selField}}   & fieldRes)
            | ({DATA_W{strobe.selZeroHi}}  & zeroHiRes);
  end

  assign cfD = (strobe.carryOnZero & srcZero)
             | (strobe.carryOnNonZero & ~srcZero)
             | (strobe.selZeroHi & zhOver);
  assign zfD = (resultD == '0);
  assign sfD = resultD[DATA_W-1];
  assign ofD = 1'b0;
  assign pfD = strobe.wrParity & ~(^resultD[PAR_W-1:0]);

  // R7: an out-of-range start cannot leave bits in the extract result
  always_comb begin
    if (strobe.selField && !fieldInRange)
      assert_field_range_R7: assert (resultD == '0);
  end

endmodule

// File: rtl/bitmanip_flag_unit.sv
module bitmanip_flag_unit
  import bmu_pkg::*;
#(
  parameter int DATA_W       = 64,
  parameter int CTRL_FIELD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              cfOut,
  output logic              zfOut,
  output logic              sfOut,
  output logic              ofOut,
  output logic              pfOut,
  output logic              afOut,
  output logic              cfWe,
  output logic              zfWe,
  output logic              sfWe,
  output logic              ofWe,
  output logic              pfWe,
  output logic              afWe
);

  bmuStrobe_t        strobe;
  logic [DATA_W-1:0] resultD;
  logic              cfD, zfD, sfD, ofD, pfD;

  bmu_ctrl u_ctrl (
    .opcode (opcode),
    .strobe (strobe)
  );

  bmu_datapath #(
    .DATA_W       (DATA_W),
    .CTRL_FIELD_W (CTRL_FIELD_W)
  ) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe),
    .resultD (resultD),
    .cfD     (cfD),
    .zfD     (zfD),
    .sfD     (sfD),
    .ofD     (ofD),
    .pfD     (pfD)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      cfOut    <= 1'b0;
      zfOut    <= 1'b0;
      sfOut    <= 1'b0;
      ofOut    <= 1'b0;
      pfOut    <= 1'b0;
      cfWe     <= 1'b0;
      zfWe     <= 1'b0;
      sfWe     <= 1'b0;
      ofWe     <= 1'b0;
      pfWe     <= 1'b0;
    end else begin
      outValid <= inValid;
      cfWe     <= inValid & strobe.wrArith;
      zfWe     <= inValid & strobe.wrArith;
      sfWe     <= inValid & strobe.wrArith;
      ofWe     <= inValid & strobe.wrArith;
      pfWe     <= inValid & strobe.wrParity;
      if (inValid) begin
        result <= resultD;
        cfOut  <= cfD;
        zfOut  <= zfD;
        sfOut  <= sfD;
        ofOut  <= ofD;
        pfOut  <= pfD;
      end
    end
  end

  assign afOut = 1'b0;
  assign afWe  = 1'b0;

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_no_we_R11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(cfWe | zfWe | sfWe | ofWe | pfWe));

  assert_carry_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == OP_MASKLOW) |=> (cfWe && cfOut == ($past(opA) == '0)));

  assert_parity_we_R8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (pfWe == ($past(opcode) == OP_FIELD)));

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && zfWe) |-> (zfOut == (result == '0)));

  assert_zerohi_over_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == OP_ZEROHI && int'(opB[CTRL_FIELD_W-1:0]) >= DATA_W)
      |=> (cfOut && result == $past(opA)));

endmodule

// File: tb/bitmanip_flag_unit_tb.sv
`timescale 1ns/1ps
module bitmanip_flag_unit_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [2:0]  opcode;
  logic [63:0] opA, opB;
  logic        outValid;
  logic [63:0] result;
  logic cfOut, zfOut, sfOut, ofOut, pfOut, afOut;
  logic cfWe, zfWe, sfWe, ofWe, pfWe, afWe;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  bitmanip_flag_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result),
    .cfOut(cfOut), .zfOut(zfOut), .sfOut(sfOut), .ofOut(ofOut),
    .pfOut(pfOut), .afOut(afOut), .cfWe(cfWe), .zfWe(zfWe),
    .sfWe(sfWe), .ofWe(ofWe), .pfWe(pfWe), .afWe(afWe)
  );

  typedef struct packed {
    logic        v;
    logic [2:0]  op;
    logic [63:0] r;
    logic [4:0]  fl;  // {cf,zf,sf,of,pf}
    logic [4:0]  we;  // {cf,zf,sf,of,pf}
  } exp_t;

  exp_t expQ[$];

  function automatic exp_t model(input logic valid, input logic [2:0] op,
                                 input logic [63:0] a, input logic [63:0] b);
    exp_t e;
    int st, ln, idx, ones;
    logic cf, pf;
    e = '0;
    e.v = valid;
    e.op = op;
    cf = 1'b0;
    pf = 1'b0;
    if (!valid) return e;
    case (op)
      3'd0: e.r = a & ~b;
      3'd1: begin
        for (int i = 0; i < 64; i++) if (a[i]) begin e.r[i] = 1'b1; break; end
        cf = (a != 0);
      end
      3'd2: begin
        for (int i = 0; i < 64; i++) begin e.r[i] = 1'b1; if (a[i]) break; end
        cf = (a == 0);
      end
      3'd3: begin
        e.r = a;
        for (int i = 0; i < 64; i++) if (a[i]) begin e.r[i] = 1'b0; break; end
        cf = (a == 0);
      end
      3'd4: begin
        st = int'(b[7:0]);
        ln = int'(b[15:8]);
        for (int i = 0; i < 64; i++)
          if (i < ln && st + i < 64) e.r[i] = a[st + i];
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(e.r[i]);
        pf = (ones % 2 == 0);
      end
      3'd5: begin
        idx = int'(b[7:0]);
        if (idx >= 64) begin e.r = a; cf = 1'b1; end
        else for (int i = 0; i < idx; i++) e.r[i] = a[i];
      end
      default: e.r = '0;
    endcase
    if (op <= 3'd5) begin
      e.fl = {cf, (e.r == 0), e.r[63], 1'b0, pf};
      e.we = {4'b1111, (op == 3'd4)};
    end
    return e;
  endfunction

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R6/R7";
      3'd5: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic compare(input exp_t e);
    chk(outValid == e.v, "R11", "outValid", 64'(outValid), 64'(e.v));
    if (!e.v) begin
      chk({cfWe, zfWe, sfWe, ofWe, pfWe} == 5'b0, "R11", "idle enables",
          64'({cfWe, zfWe, sfWe, ofWe, pfWe}), 64'(0));
      return;
    end
    chk(result == e.r, opTag(e.op), "result", result, e.r);
    chk({cfWe, zfWe, sfWe, ofWe, pfWe} == e.we,
        (e.op == 3'd4) ? "R8" : ((e.op > 3'd5) ? "R12" : "R5"), "enables",
        64'({cfWe, zfWe, sfWe, ofWe, pfWe}), 64'(e.we));
    if (e.op <= 3'd5) begin
      // carry rule lives with each operation's requirement
      chk(cfOut == e.fl[4], (e.op == 3'd4) ? "R8" : opTag(e.op), "carry",
          64'(cfOut), 64'(e.fl[4]));
      chk({zfOut, sfOut, ofOut} == e.fl[3:1], (e.op == 3'd4) ? "R8" : "R5",
          "zf/sf/of", 64'({zfOut, sfOut, ofOut}), 64'(e.fl[3:1]));
      if (e.op == 3'd4)
        chk(pfOut == e.fl[0], "R8", "parity", 64'(pfOut), 64'(e.fl[0]));
    end
    chk(afOut == 1'b0 && afWe == 1'b0, "R10", "aux carry",
        64'({afOut, afWe}), 64'(0));
  endtask

  task automatic apply(input logic v, input logic [2:0] op,
                       input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    if (expQ.size() > 0) compare(expQ.pop_front());
    inValid = v;
    opcode  = op;
    opA     = a;
    opB     = b;
    expQ.push_back(model(v, op, a, b));
  endtask

  function automatic logic [63:0] ctl(input int start, input int len);
    return {48'h0, 8'(len), 8'(start)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  %0d/%0d checks passed", checks - fails + 1 - 1, checks + 1);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; opcode = '0; opA = '0; opB = '0;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(outValid == 1'b0 && result == '0, "R13", "reset valid/result",
        result, 64'(0));
    chk({cfWe, zfWe, sfWe, ofWe, pfWe, afWe} == 6'b0, "R13", "reset enables",
        64'({cfWe, zfWe, sfWe, ofWe, pfWe, afWe}), 64'(0));
    rstN = 1'b1;

    // R1
    apply(1, 3'd0, 64'hF0F0_1234_5678_FFFF, 64'h00FF_FF00_0F0F_00F0);
    apply(1, 3'd0, 64'h8000_0000_0000_0000, 64'h0);
    apply(1, 3'd0, 64'hFFFF, 64'hFFFF);
    // R2/R3/R4 incl. zero and top-bit sources
    for (int op = 1; op <= 3; op++) begin
      apply(1, 3'(op), 64'h0, 64'h0);
      apply(1, 3'(op), 64'h8000_0000_0000_0000, 64'h0);
      apply(1, 3'(op), 64'h0000_0ABC_0000_1000, 64'h0);
      apply(1, 3'(op), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    end
    apply(0, 3'd0, 64'h1, 64'h1);  // R11 idle gap
    // R6/R7/R8 field extract corners
    apply(1, 3'd4, 64'hDEAD_BEEF_CAFE_F00D, ctl(4, 12));
    apply(1, 3'd4, 64'hDEAD_BEEF_CAFE_F00D, ctl(64, 4));
    apply(1, 3'd4, 64'hDEAD_BEEF_CAFE_F00D, ctl(200, 4));
    apply(1, 3'd4, 64'hDEAD_BEEF_CAFE_F00D, ctl(8, 0));
    apply(1, 3'd4, 64'hDEAD_BEEF_CAFE_F00D, ctl(0, 64));
    apply(1, 3'd4, 64'hDEAD_BEEF_CAFE_F00D, ctl(12, 255));
    apply(1, 3'd4, 64'hDEAD_BEEF_CAFE_F00D, ctl(60, 10));
    apply(1, 3'd4, 64'h8000_0000_0000_0000, ctl(0, 64));
    apply(1, 3'd4, 64'h0000_0000_0000_0003, ctl(0, 8));
    apply(0, 3'd4, 64'h0, 64'h0);
    // R9 zero-high corners
    apply(1, 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, ctl(0, 0));
    apply(1, 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, ctl(63, 0));
    apply(1, 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, ctl(64, 0));
    apply(1, 3'd5, 64'h8123_4567_89AB_CDEF, ctl(255, 0));
    apply(1, 3'd5, 64'h8123_4567_89AB_CDEF, ctl(17, 3));
    // R12 undefined opcodes
    apply(1, 3'd6, 64'h1234, 64'h5678);
    apply(1, 3'd7, 64'hFFFF, 64'h0);
    // mixed patterns with idle cycles
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (n % 3 == 0) b[15:0] = {8'($urandom_range(0, 80)), 8'($urandom_range(0, 80))};
      if (n % 5 == 0) a = a & {$urandom, $urandom};
      apply(1'($urandom_range(0, 7) != 0), 3'($urandom_range(0, 7)), a, b);
    end
    apply(0, 3'd0, 64'h0, 64'h0);
    apply(0, 3'd0, 64'h0, 64'h0);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule